// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block stores eight 32-bit integer registers and lets every access choose its width: a full 32-bit access, a 16-bit access to the low half of any register, or an 8-bit access to one of the two low bytes of the first four registers. All three widths work on the same flops, so a narrow write changes only its own slice, and a read of any slice sees what the other widths last wrote.

There are two combinational read ports and one write port that updates on the clock edge. Each port takes a 3-bit register selector and a 2-bit size code. Narrow reads come back zero-extended to 32 bits. A narrow write takes its value from the low bits of the write data and merges it into the addressed register. An active-low asynchronous reset clears the whole file.

Top module: `alias_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads as zero until it is written.
- R2: A size code with bit 1 set (2'b10 or 2'b11) selects the full 32-bit register named by the selector. A write replaces all 32 bits, and a read returns all 32 bits.
- R3: Size code 2'b01 selects bits 15:0 of the register named by the selector, for all eight selectors.
- R4: Size code 2'b00 with selector 0 to 3 selects bits 7:0 of registers 0 to 3.
- R5: Size code 2'b00 with selector 4 to 7 selects bits 15:8 of registers 0 to 3, in that order (selector 4 maps to register 0).
- R6: A byte or word write leaves every bit of the register outside the addressed slice unchanged.
- R7: A byte or word read returns the slice in the low bits of the read data, with all upper bits zero.
- R8: A read of a register that is being written in the same cycle returns the value from before the write. The new value can be read from the next cycle on.
- R9: The two read ports are independent of each other, and each may address any slice in the same cycle.
- R10: While the write enable is low, the write selector, size and data have no effect on the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| wsel_i | input | 3 | Write register selector |
| wsize_i | input | 2 | Write size code |
| wdata_i | input | 32 | Write data, narrow values in the low bits |
| ra_sel_i | input | 3 | Read port A selector |
| ra_size_i | input | 2 | Read port A size code |
| ra_data_o | output | 32 | Read port A data |
| rb_sel_i | input | 3 | Read port B selector |
| rb_size_i | input | 2 | Read port B size code |
| rb_data_o | output | 32 | Read port B data |

## Verification
A read and a write can hit the same register in the same cycle, often through different aliases, for example a read of the high byte while the low byte or the whole register is being written. The bench provokes this in two ways. Directed steps point a read port at the slice being written. A long random run draws selectors from only eight values, so same-register overlaps happen often. Each read is sampled before the clock edge and compared with a reference model that has not yet taken that cycle's write, which checks that the old value is returned. The next step then checks that the merged value has arrived with its neighbouring bits intact.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_FULL  = 2'b10,
    SZ_FULL2 = 2'b11
  } acc_size_e;
endpackage

// File: rtl/rf_slice_decode.sv
module rf_slice_decode
  import alias_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned SH_W    = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  sel_i,
  input  logic [1:0]        size_i,
  output logic [IDX_W-1:0]  phys_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [SH_W-1:0]   shift_o
);
  localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'({BYTE_W{1'b1}});
  localparam logic [DATA_W-1:0] WORD_MASK = DATA_W'({WORD_W{1'b1}});

  always_comb begin
    phys_o  = sel_i;
    shift_o = '0;
    mask_o  = '1;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        // upper half of selector space aliases high bytes of lower half
        phys_o = {1'b0, sel_i[IDX_W-2:0]};
        if (sel_i[IDX_W-1]) shift_o = SH_W'(BYTE_W);
        mask_o = BYTE_MASK << shift_o;
      end
      SZ_WORD:  mask_o = WORD_MASK;
      default: ;
    endcase
  end
endmodule

// File: rtl/rf_read_extract.sv
module rf_read_extract #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [DATA_W-1:0] data_o
);
  assign data_o = (word_i & mask_i) >> shift_i;
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [DATA_W-1:0] new_o
);
  assign new_o = (old_i & ~mask_i) | ((wdata_i << shift_i) & mask_i);
endmodule

// File: rtl/rf_entry.sv
module rf_entry #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned SH_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wsel_i,
  input  logic [1:0]        wsize_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ra_sel_i,
  input  logic [1:0]        ra_size_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_sel_i,
  input  logic [1:0]        rb_size_i,
  output logic [DATA_W-1:0] rb_data_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  logic [IDX_W-1:0]  w_phys, a_phys, b_phys;
  logic [DATA_W-1:0] w_mask, a_mask, b_mask;
  logic [SH_W-1:0]   w_shift, a_shift, b_shift;
  logic [DATA_W-1:0] w_merged;

  rf_slice_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dec_w (
    .sel_i(wsel_i), .size_i(wsize_i),
    .phys_o(w_phys), .mask_o(w_mask), .shift_o(w_shift));
  rf_slice_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dec_a (
    .sel_i(ra_sel_i), .size_i(ra_size_i),
    .phys_o(a_phys), .mask_o(a_mask), .shift_o(a_shift));
  rf_slice_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dec_b (
    .sel_i(rb_sel_i), .size_i(rb_size_i),
    .phys_o(b_phys), .mask_o(b_mask), .shift_o(b_shift));

  rf_write_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i(regs_q[w_phys]), .wdata_i(wdata_i),
    .mask_i(w_mask), .shift_i(w_shift), .new_o(w_merged));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    rf_entry #(.DATA_W(DATA_W)) u_entry (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (we_i && (w_phys == IDX_W'(g))),
      .d_i   (w_merged),
      .q_o   (regs_q[g])
    );
  end

  rf_read_extract #(.DATA_W(DATA_W)) u_rd_a (
    .word_i(regs_q[a_phys]), .mask_i(a_mask), .shift_i(a_shift), .data_o(ra_data_o));
  rf_read_extract #(.DATA_W(DATA_W)) u_rd_b (
    .word_i(regs_q[b_phys]), .mask_i(b_mask), .shift_i(b_shift), .data_o(rb_data_o));
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk
  import alias_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [IDX_W-1:0]  wsel_i,
  input logic [1:0]        wsize_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [IDX_W-1:0]  ra_sel_i,
  input logic [1:0]        ra_size_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [IDX_W-1:0]  rb_sel_i,
  input logic [1:0]        rb_size_i,
  input logic [DATA_W-1:0] rb_data_o
);
  localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'({BYTE_W{1'b1}});
  localparam logic [DATA_W-1:0] WORD_MASK = DATA_W'({WORD_W{1'b1}});

  a_r2_full_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wsize_i[1]) |=>
      ((ra_sel_i != $past(wsel_i)) || !ra_size_i[1] || (ra_data_o == $past(wdata_i))));

  a_r3_word_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wsize_i == 2'b01) |=>
      ((ra_sel_i != $past(wsel_i)) || (ra_size_i != 2'b01) ||
       (ra_data_o == ($past(wdata_i) & WORD_MASK))));

  // R4 and R5: byte alias written then read through the same selector
  a_r4_byte_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wsize_i == 2'b00) |=>
      ((rb_sel_i != $past(wsel_i)) || (rb_size_i != 2'b00) ||
       (rb_data_o == ($past(wdata_i) & BYTE_MASK))));

  a_r7_zero_ext_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_size_i == 2'b00) |-> ((ra_data_o & ~BYTE_MASK) == '0));

  a_r7_zero_ext_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_size_i == 2'b01) |-> ((rb_data_o & ~WORD_MASK) == '0));

  a_r10_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && $stable(ra_sel_i) && $stable(ra_size_i)) |-> $stable(ra_data_o));
endmodule

bind alias_regfile alias_regfile_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wsel_i(wsel_i), .wsize_i(wsize_i),
  .wdata_i(wdata_i), .ra_sel_i(ra_sel_i), .ra_size_i(ra_size_i), .ra_data_o(ra_data_o),
  .rb_sel_i(rb_sel_i), .rb_size_i(rb_size_i), .rb_data_o(rb_data_o));

// File: tb/alias_regfile_tb_top.sv
module alias_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  wsel_i = '0;
  logic [1:0]  wsize_i = '0;
  logic [31:0] wdata_i = '0;
  logic [2:0]  ra_sel_i = '0, rb_sel_i = '0;
  logic [1:0]  ra_size_i = 2'b10, rb_size_i = 2'b10;
  logic [31:0] ra_data_o, rb_data_o;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [31:0] model [8];

  always #4 clk_i = ~clk_i;

  alias_regfile dut_i (
    .clk_i, .rst_ni, .we_i, .wsel_i, .wsize_i, .wdata_i,
    .ra_sel_i, .ra_size_i, .ra_data_o, .rb_sel_i, .rb_size_i, .rb_data_o);

  function automatic logic [31:0] exp_rd(int sel, int size);
    if (size >= 2) return model[sel];
    if (size == 1) return {16'h0, model[sel][15:0]};
    if (sel < 4)   return {24'h0, model[sel][7:0]};
    return {24'h0, model[sel-4][15:8]};
  endfunction

  function automatic void model_wr(int sel, int size, logic [31:0] d);
    if (size >= 2)     model[sel] = d;
    else if (size == 1) model[sel][15:0] = d[15:0];
    else if (sel < 4)  model[sel][7:0] = d[7:0];
    else               model[sel-4][15:8] = d[7:0];
  endfunction

  function automatic string tag(int sel, int size);
    if (size >= 2) return "R2";
    if (size == 1) return "R3/R7";
    return (sel < 4) ? "R4/R7" : "R5/R7";
  endfunction

  task automatic check(string req, int sel, int size, logic [31:0] act);
    logic [31:0] e;
    e = exp_rd(sel, size);
    n_vec++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s sel=%0d size=%0d actual=%h expected=%h", req, sel, size, act, e);
    end
  endtask

  // reads are sampled before the edge, so a same-cycle write must not show (R8)
  task automatic step(bit we, int ws, int wz, logic [31:0] wd,
                      int as, int az, int bs, int bz, string req);
    @(negedge clk_i);
    we_i = we; wsel_i = 3'(ws); wsize_i = 2'(wz); wdata_i = wd;
    ra_sel_i = 3'(as); ra_size_i = 2'(az); rb_sel_i = 3'(bs); rb_size_i = 2'(bz);
    #2;
    check((req == "") ? tag(as, az) : req, as, az, ra_data_o);
    check((req == "") ? tag(bs, bz) : req, bs, bz, rb_data_o);
    @(posedge clk_i);
    if (we) model_wr(ws, wz, wd);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    #3;
    for (int i = 0; i < 8; i++) begin
      ra_sel_i = 3'(i); #1; check("R1", i, 2, ra_data_o);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, i, 2, i, 1, "R1");

    // full-width fill, then every alias of every register on both ports (R9)
    for (int i = 0; i < 8; i++) step(1, i, 2, 32'hA0B1C2D3 ^ (32'h01010101 * i), i, 2, 0, 2, "");
    for (int s = 0; s < 8; s++)
      for (int z = 0; z < 4; z++) step(0, 0, 0, 0, s, z, 7 - s, 3 - z, "");

    // R6: AH/AL interplay and word writes keep neighbours
    step(1, 0, 2, 32'h11223344, 0, 2, 0, 2, "R6");
    step(1, 0, 0, 32'hFFFFFFAA, 0, 2, 4, 0, "R6");
    step(1, 4, 0, 32'hFFFFFFBB, 0, 2, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 2, 4, 0, "R6");
    step(1, 3, 1, 32'hDEAD5A5A, 3, 2, 7, 0, "R6");
    step(0, 0, 0, 0, 3, 2, 3, 0, "R6");

    // R8: read targets the slice written in the same cycle
    step(1, 1, 2, 32'hCAFEF00D, 1, 2, 5, 0, "R8");
    step(1, 5, 0, 32'h00000077, 1, 2, 5, 0, "R8");
    step(0, 0, 0, 0, 1, 2, 5, 0, "R8");

    // R10: write enable low leaves contents alone
    step(0, 2, 2, 32'h12345678, 2, 2, 2, 1, "R10");
    step(0, 6, 0, 32'h000000EE, 2, 2, 6, 0, "R10");

    // exhaustive write sweep with check of all aliases afterwards
    for (int s = 0; s < 8; s++)
      for (int z = 0; z < 3; z++) begin
        step(1, s, z, 32'h5EED0000 + (s * 16 + z) * 32'h01030507, s, z, s, 2, "");
        for (int r = 0; r < 8; r++) step(0, 0, 0, 0, r, 2, r, 0, "");
      end

    // random mixed-width run
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 3), $urandom,
           $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 7), $urandom_range(0, 3), "");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule